// File: doc/BRIEF.md
# Gated Frequency Counter

The block measures how often a digital input toggles. A fixed reference clock feeds a divider chain: a programmable prescaler produces a base timebase tick, and a row of divide-by-ten stages produces ticks ten and a hundred times slower. The tick chosen by a gate-time select code toggles a gate flip-flop. While the gate is open, every rising edge of the input advances a counter. When the gate closes, the count is presented on the result port and a one-cycle valid strobe is raised.

With the prescaler set to one tenth of the reference frequency, the three windows are 0.1 s, 1 s and 10 s. The result then reads in units of 10 Hz, 1 Hz and 0.1 Hz. The input is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector, so it must toggle slower than half the reference rate. A counter that saturates raises an overflow flag alongside its result.

Top module: `freq_gate_counter`

## Requirements
- R1: Select code k (two bits) sets the window to PRE_DIV × 10^k reference cycles. Code 0 is the shortest, code 1 is ten times longer and code 2 is a hundred times longer. Code 3 behaves as code 2.
- R2: Open and closed spans alternate, and each lasts exactly the selected window. A result is produced at the end of every open span, so results arrive every two windows.
- R3: Each result equals the number of rising edges of `sig_in` seen during that open span. The counter starts from zero in every window, so a 1 s window reads in Hz, a 10 s window in 0.1 Hz units and a 0.1 s window in 10 Hz units.
- R4: Rising edges that arrive while the gate is closed do not contribute to any result.
- R5: `meas_valid` is high for exactly one cycle per result, and `meas_count` holds its value between valid pulses.
- R6: A change on `gate_sel` does not alter a window already in progress. It takes effect from the next opening of the gate.
- R7: The count stops at 2^CNT_W − 1. If an edge arrives at that value, `meas_ovf` is set together with the result. It then holds until the next result, which clears it when that window did not saturate.
- R8: A synchronous `rst` clears `meas_count`, `meas_valid` and `meas_ovf`, closes the gate and restarts the divider chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock driving all logic |
| rst | input | 1 | Synchronous reset, active high |
| gate_sel | input | SEL_W | Gate-time select code (0, 1, 2; 3 acts as 2) |
| sig_in | input | 1 | Asynchronous signal to be measured |
| meas_count | output | CNT_W | Edge count of the last completed window |
| meas_valid | output | 1 | One-cycle strobe when a new count is presented |
| meas_ovf | output | 1 | Counter saturated in the last completed window |

## Verification
The assertions assume that `rst` is held for at least two cycles. They also assume that `sig_in` stays low or high for at least two reference cycles at a time, so every rising edge survives the synchronizer and is counted once. The stimulus drives `sig_in` on the falling clock edge with half-periods of two cycles or more, and it keeps reset asserted for several cycles. Each vector waits out two results after a change of select or rate before it compares a count. This keeps the assumptions about window length and edge spacing intact across those changes.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
   localparam int DECADE = 10;

   // reference cycles in one window for a given decade index
   function automatic longint win_cycles(input longint base, input int k);
      longint v;
      v = base;
      for (int i = 0; i < k; i++) v = v * DECADE;
      return v;
   endfunction
endpackage

// File: rtl/fgc_timebase.sv
module fgc_timebase
   import fgc_pkg::*;
#(
   parameter int PRE_DIV = 1_000_000,
   parameter int DECADES = 2,
   parameter int SEL_W   = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel_req,
   output logic             gate_open,
   output logic             gate_close,
   output logic [SEL_W-1:0] sel_act
);
   localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   logic [PRE_W-1:0] pre_q;
   logic [DECADES:0] tick;
   logic             sel_tick;
   logic [SEL_W-1:0] sel_clamped;

   assign sel_clamped = (int'(sel_req) > DECADES) ? SEL_W'(DECADES) : sel_req;
   assign sel_tick    = tick[sel_act];
   assign tick[0]     = (pre_q == PRE_W'(PRE_DIV - 1));

   // prescaler, restarted on every selected tick so each span is exact
   always_ff @(posedge clk) begin
      if (rst || sel_tick || tick[0]) pre_q <= '0;
      else                            pre_q <= pre_q + 1'b1;
   end

   // decade stages
   for (genvar k = 1; k <= DECADES; k++) begin : g_decade
      logic [3:0] dc_q;
      always_ff @(posedge clk) begin
         if (rst || sel_tick)    dc_q <= '0;
         else if (tick[k-1])     dc_q <= (dc_q == 4'd9) ? 4'd0 : dc_q + 4'd1;
      end
      assign tick[k] = tick[k-1] && (dc_q == 4'd9);
   end

   // gate toggle flip-flop; the select is captured as the gate opens
   always_ff @(posedge clk) begin
      if (rst) begin
         gate_open <= 1'b0;
         sel_act   <= '0;
      end else if (sel_tick) begin
         gate_open <= ~gate_open;
         if (!gate_open) sel_act <= sel_clamped;
      end
   end

   assign gate_close = sel_tick && gate_open;
endmodule

// File: rtl/fgc_edge_sync.sv
module fgc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise = sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/fgc_accum.sv
module fgc_accum #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             gate_open,
   input  logic             gate_close,
   input  logic             rise,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] res_q,
   output logic             res_vld,
   output logic             res_ovf
);
   logic             sat_q;
   logic             hit;
   logic             at_max;
   logic [CNT_W-1:0] cnt_nx;
   logic             sat_nx;

   assign hit    = gate_open && rise;
   assign at_max = &count_q;
   assign cnt_nx = (hit && !at_max) ? count_q + 1'b1 : count_q;
   assign sat_nx = sat_q || (hit && at_max);

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
         sat_q   <= 1'b0;
         res_q   <= '0;
         res_vld <= 1'b0;
         res_ovf <= 1'b0;
      end else if (gate_close) begin
         res_q   <= cnt_nx;
         res_ovf <= sat_nx;
         res_vld <= 1'b1;
         count_q <= '0;
         sat_q   <= 1'b0;
      end else begin
         count_q <= cnt_nx;
         sat_q   <= sat_nx;
         res_vld <= 1'b0;
      end
   end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
   parameter int PRE_DIV     = 1_000_000,
   parameter int DECADES     = 2,
   parameter int SEL_W       = 2,
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             ref_clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] gate_sel,
   input  logic             sig_in,
   output logic [CNT_W-1:0] meas_count,
   output logic             meas_valid,
   output logic             meas_ovf
);
   if (PRE_DIV < 2)                      begin : g_bad_pre  $error("PRE_DIV must be at least 2");  end
   if (DECADES < 0)                      begin : g_bad_dec  $error("DECADES must not be negative"); end
   if (SEL_W < $clog2(DECADES + 1))      begin : g_bad_sel  $error("SEL_W too narrow for DECADES"); end
   if (SYNC_STAGES < 2)                  begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   if (CNT_W < 2)                        begin : g_bad_cnt  $error("CNT_W must be at least 2");     end

   logic             gate_open;
   logic             gate_close;
   logic [SEL_W-1:0] sel_act;
   logic             rise;
   logic [CNT_W-1:0] count_q;

   fgc_timebase #(.PRE_DIV(PRE_DIV), .DECADES(DECADES), .SEL_W(SEL_W)) u_tb (
      .clk        (ref_clk),
      .rst        (rst),
      .sel_req    (gate_sel),
      .gate_open  (gate_open),
      .gate_close (gate_close),
      .sel_act    (sel_act)
   );

   fgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (ref_clk),
      .rst  (rst),
      .din  (sig_in),
      .rise (rise)
   );

   fgc_accum #(.CNT_W(CNT_W)) u_acc (
      .clk        (ref_clk),
      .rst        (rst),
      .gate_open  (gate_open),
      .gate_close (gate_close),
      .rise       (rise),
      .count_q    (count_q),
      .res_q      (meas_count),
      .res_vld    (meas_valid),
      .res_ovf    (meas_ovf)
   );
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker
   import fgc_pkg::*;
#(
   parameter int PRE_DIV = 20,
   parameter int SEL_W   = 2,
   parameter int CNT_W   = 8
) (
   input logic             ref_clk,
   input logic             rst,
   input logic             gate_open,
   input logic [SEL_W-1:0] sel_act,
   input logic [CNT_W-1:0] count_q,
   input logic [CNT_W-1:0] meas_count,
   input logic             meas_valid,
   input logic             meas_ovf
);
   longint span_q;

   always_ff @(posedge ref_clk) begin
      if (rst || !gate_open) span_q <= 0;
      else                   span_q <= span_q + 1;
   end

   // R1: an open span lasts the selected number of cycles
   a_r1_window_len: assert property (@(posedge ref_clk) disable iff (rst)
      (!gate_open && span_q != 0) |-> span_q == win_cycles(PRE_DIV, int'(sel_act)));

   // R4: nothing accumulates while the gate is closed
   a_r4_count_idle: assert property (@(posedge ref_clk) disable iff (rst)
      !gate_open |-> count_q == '0);

   a_r5_valid_pulse: assert property (@(posedge ref_clk) disable iff (rst)
      meas_valid |=> !meas_valid);

   a_r5_result_hold: assert property (@(posedge ref_clk) disable iff (rst)
      !$stable(meas_count) |-> meas_valid);

   a_r7_overflow_hold: assert property (@(posedge ref_clk) disable iff (rst)
      !$stable(meas_ovf) |-> meas_valid);

   a_r7_ovf_max: assert property (@(posedge ref_clk) disable iff (rst)
      (meas_valid && meas_ovf) |-> (&meas_count));
endmodule

bind freq_gate_counter fgc_checker #(.PRE_DIV(PRE_DIV), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
   .ref_clk    (ref_clk),
   .rst        (rst),
   .gate_open  (gate_open),
   .sel_act    (sel_act),
   .count_q    (count_q),
   .meas_count (meas_count),
   .meas_valid (meas_valid),
   .meas_ovf   (meas_ovf)
);

// File: tb/freq_gate_counter_bench.sv
module freq_gate_counter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PRE       = 20;
   localparam int CW        = 8;
   localparam int WATCHDOG  = 180_000;
   localparam int NVEC      = 10;
   // each entry: {select, input half-period in cycles, expected count, expected overflow}
   localparam logic [31:0] VEC [NVEC] = '{
      {8'd0, 8'd2,  8'd5,   8'd0},
      {8'd0, 8'd5,  8'd2,   8'd0},
      {8'd1, 8'd2,  8'd50,  8'd0},
      {8'd1, 8'd4,  8'd25,  8'd0},
      {8'd1, 8'd10, 8'd10,  8'd0},
      {8'd2, 8'd5,  8'd200, 8'd0},
      {8'd2, 8'd50, 8'd20,  8'd0},
      {8'd2, 8'd2,  8'd255, 8'd1},
      {8'd3, 8'd10, 8'd100, 8'd0},
      {8'd1, 8'd25, 8'd4,   8'd0}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    gate_sel = 2'd0;
   logic          sig_in = 1'b0;
   logic [CW-1:0] meas_count;
   logic          meas_valid;
   logic          meas_ovf;

   int errors = 0;
   int checks = 0;
   int half   = 0;
   int phase  = 0;
   int cycles = 0;
   logic [CW-1:0] got_cnt;
   logic          got_ovf;

   freq_gate_counter #(.PRE_DIV(PRE), .DECADES(2), .SEL_W(2), .CNT_W(CW), .SYNC_STAGES(2)) u_freq_gate_counter (
      .ref_clk    (clk),
      .rst        (rst),
      .gate_sel   (gate_sel),
      .sig_in     (sig_in),
      .meas_count (meas_count),
      .meas_valid (meas_valid),
      .meas_ovf   (meas_ovf)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // square wave source, updated away from the active edge
   always @(negedge clk) begin
      if (half > 0) begin
         if (phase >= half - 1) begin
            phase  = 0;
            sig_in = ~sig_in;
         end else begin
            phase = phase + 1;
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > WATCHDOG) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
         summary();
         $finish;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_result();
      do @(negedge clk); while (!meas_valid);
      got_cnt = meas_count;
      got_ovf = meas_ovf;
   endtask

   task automatic set_rate(input int h);
      half  = h;
      phase = 0;
      if (h == 0) sig_in = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R8: outputs cleared while reset is held
      check("R8 count in reset", meas_count, 0);
      check("R8 valid in reset", meas_valid, 0);
      check("R8 ovf in reset", meas_ovf, 0);
      rst = 1'b0;

      // R1 R2 R3 R7: vector table
      for (int i = 0; i < NVEC; i++) begin
         gate_sel = VEC[i][25:24];
         set_rate(int'(VEC[i][23:16]));
         wait_result();
         wait_result();
         wait_result();
         check($sformatf("R3 count vec %0d", i), got_cnt, VEC[i][15:8]);
         check($sformatf("R7 ovf vec %0d", i), got_ovf, VEC[i][0]);
         @(negedge clk);
         check($sformatf("R5 strobe one cycle vec %0d", i), meas_valid, 0);
         check($sformatf("R5 count held vec %0d", i), meas_count, got_cnt);
         if (VEC[i][0]) begin
            repeat (100) @(negedge clk);
            check("R7 ovf held between results", meas_ovf, 1);
         end
      end

      // R4: edges only during a closed span
      gate_sel = 2'd2;
      set_rate(0);
      wait_result();
      wait_result();
      set_rate(3);
      repeat (1500) @(negedge clk);
      set_rate(0);
      wait_result();
      check("R4 closed-span edges ignored", got_cnt, 0);

      // R6: select change mid-window
      gate_sel = 2'd1;
      set_rate(2);
      wait_result();
      wait_result();
      wait_result();
      repeat (250) @(negedge clk);
      gate_sel = 2'd0;
      wait_result();
      check("R6 running window keeps old select", got_cnt, 50);
      wait_result();
      check("R6 next window uses new select", got_cnt, 5);

      // R2: result spacing is two windows
      begin
         int gap;
         gap = 0;
         do begin @(negedge clk); gap++; end while (!meas_valid);
         check("R2 result spacing", gap, 2 * PRE);
      end

      // R8: reset in mid-run
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 count after reset", meas_count, 0);
      check("R8 ovf after reset", meas_ovf, 0);
      rst = 1'b0;
      set_rate(5);
      wait_result();
      wait_result();
      check("R3 count after reset", got_cnt, 2);

      summary();
      $finish;
   end
endmodule